// File: doc/BRIEF.md
# Receive Sample Phase Tuning Engine

This block picks the receive-clock sampling phase for a card interface. It tries each of eight phases in turn. For each phase it presents the candidate on a 3-bit phase output, raises a trial request and waits for an external pass or fail answer. That answer would typically come from issuing a tuning command to the card. The answers are gathered into an 8-bit pass mask, one bit per phase.

Once all eight phases have been tried, a window search over the mask picks the phase that sits deepest inside a run of passing settings. The mask is treated as circular, so phase 7 is the neighbour of phase 0. The chosen phase is applied to the phase output and kept as the tuned value. If no phase passed, the engine flags an error and leaves the applied phase where it was.

Top module: `ptune_engine`

## Requirements
- R1: After a synchronous reset, `sample_phase_o` and `tuned_phase_o` equal `RESET_PHASE` (default 0), and `trial_req_o`, `busy_o`, `done_o` and `error_o` are all low.
- R2: A sweep starts from the phase applied when the start is accepted. Each trial first advances the phase by one modulo 8 and then requests. Exactly eight trials are made, and the last one is at the starting phase.
- R3: `trial_req_o` stays high and `sample_phase_o` stays unchanged until `trial_ack_i` is seen. An acknowledge while no request is pending has no effect.
- R4: An acknowledged trial with `trial_pass_i` high marks its phase as passing. With `trial_pass_i` low the phase is marked failing.
- R5: The first search tier looks for the lowest phase i such that phases i-2, i-1, i, i+1 and i+2 (modulo 8) all passed. If one is found, it is chosen.
- R6: If the first tier finds nothing, the second tier looks for the lowest phase i such that phases i-1, i and i+1 (modulo 8) all passed. If one is found, it is chosen.
- R7: If neither wider tier finds a window, the lowest passing phase is chosen.
- R8: If no phase passed, `error_o` goes high and neither `sample_phase_o` nor `tuned_phase_o` changes.
- R9: On success, `sample_phase_o` and `tuned_phase_o` both take the chosen phase, and `error_o` is low.
- R10: `busy_o` is high from the cycle after the start is accepted until the result is applied. `done_o` pulses for exactly one cycle as the result is applied, and `busy_o` is already low in that cycle.
- R11: A start pulse while `busy_o` is high is ignored: the sweep in progress still makes exactly eight trials and then finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a tuning sweep (accepted only when idle) |
| trial_ack_i | input | 1 | Trial result is valid this cycle |
| trial_pass_i | input | 1 | Trial outcome, 1 = pass; sampled with `trial_ack_i` |
| trial_req_o | output | 1 | Trial request at the current phase |
| sample_phase_o | output | 3 | Applied sampling phase |
| tuned_phase_o | output | 3 | Last successfully tuned phase |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse when the result is applied |
| error_o | output | 1 | No phase passed in the last sweep |

## Verification
The assertions check, on every cycle, the handshake behaviour. The request must hold and the phase must stay frozen until an acknowledge arrives. Each new request must come one phase step past the previous phase. The done pulse must last one cycle with busy already low. A failed sweep must leave the phase untouched, and a successful one must leave the tuned and applied phases equal.

Other behaviour depends on the content of a whole sweep, so only the bench scenarios can show it. This covers the choice between the three search tiers, wraparound windows that cross phase 0, the exact count of eight trials, and a start pulse arriving in mid-sweep. The bench checks these against an independent model of the search.

// File: rtl/ptune_pkg.sv
package ptune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_WAIT = 2'd2,
    ST_PICK = 2'd3
  } ptune_state_e;

  localparam int TIER_COUNT = 3;
endpackage

// File: rtl/ptune_tier_scan.sv
// Scans every circular rotation of the pass mask for one window pattern
// and reports the lowest rotation at which all pattern bits pass.
module ptune_tier_scan #(
  parameter int PHASE_W = 3,
  parameter int N_PHASE = 1 << PHASE_W,
  parameter logic [N_PHASE-1:0] PATTERN = '1
) (
  input  logic [N_PHASE-1:0] mask_i,
  output logic               hit_o,
  output logic [PHASE_W-1:0] idx_o
);
  logic [2*N_PHASE-1:0] doubled;
  logic [N_PHASE-1:0]   rot_hit;

  assign doubled = {mask_i, mask_i};

  genvar r;
  generate
    for (r = 0; r < N_PHASE; r++) begin : g_rot
      // rotate right by r: bit j of rotated word is mask[(j+r) mod N]
      assign rot_hit[r] = ((doubled[r +: N_PHASE] & PATTERN) == PATTERN);
    end
  endgenerate

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N_PHASE - 1; k >= 0; k--) begin
      if (rot_hit[k]) begin
        hit_o = 1'b1;
        idx_o = PHASE_W'(k);
      end
    end
  end
endmodule

// File: rtl/ptune_window_search.sv
// Three-tier prioritised window search: wide window, narrow window,
// then any single passing phase.
module ptune_window_search #(
  parameter int PHASE_W = 3
) (
  input  logic [(1<<PHASE_W)-1:0] mask_i,
  output logic                    hit_o,
  output logic [PHASE_W-1:0]      idx_o
);
  import ptune_pkg::*;

  localparam int N_PHASE = 1 << PHASE_W;

  function automatic logic [N_PHASE-1:0] tier_pattern(input int tier);
    logic [N_PHASE-1:0] p;
    p = '0;
    p[0] = 1'b1;
    if (tier <= 1) begin
      p[1]         = 1'b1;
      p[N_PHASE-1] = 1'b1;
    end
    if (tier == 0) begin
      p[2]         = 1'b1;
      p[N_PHASE-2] = 1'b1;
    end
    return p;
  endfunction

  logic               tier_hit [TIER_COUNT];
  logic [PHASE_W-1:0] tier_idx [TIER_COUNT];

  genvar t;
  generate
    for (t = 0; t < TIER_COUNT; t++) begin : g_tier
      ptune_tier_scan #(
        .PHASE_W (PHASE_W),
        .N_PHASE (N_PHASE),
        .PATTERN (tier_pattern(t))
      ) u_scan (
        .mask_i (mask_i),
        .hit_o  (tier_hit[t]),
        .idx_o  (tier_idx[t])
      );
    end
  endgenerate

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = TIER_COUNT - 1; k >= 0; k--) begin
      if (tier_hit[k]) begin
        hit_o = 1'b1;
        idx_o = tier_idx[k];
      end
    end
  end
endmodule

// File: rtl/ptune_sweep_ctrl.sv
// Sweep sequencer: advances the phase, runs the req/ack trial,
// gathers the pass mask and applies the search result.
module ptune_sweep_ctrl #(
  parameter int PHASE_W     = 3,
  parameter int RESET_PHASE = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    ack_i,
  input  logic                    pass_i,
  input  logic                    pick_hit_i,
  input  logic [PHASE_W-1:0]      pick_idx_i,
  output logic [(1<<PHASE_W)-1:0] mask_o,
  output logic [PHASE_W-1:0]      phase_o,
  output logic [PHASE_W-1:0]      tuned_o,
  output logic                    req_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o
);
  import ptune_pkg::*;

  ptune_state_e       state;
  logic [PHASE_W-1:0] origin;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      origin  <= PHASE_W'(RESET_PHASE);
      phase_o <= PHASE_W'(RESET_PHASE);
      tuned_o <= PHASE_W'(RESET_PHASE);
      mask_o  <= '0;
      req_o   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            origin <= phase_o;
            mask_o <= '0;
            busy_o <= 1'b1;
            err_o  <= 1'b0;
            state  <= ST_STEP;
          end
        end
        ST_STEP: begin
          phase_o <= phase_o + 1'b1;
          req_o   <= 1'b1;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_i) begin
            req_o <= 1'b0;
            if (pass_i) mask_o[phase_o] <= 1'b1;
            state <= (phase_o == origin) ? ST_PICK : ST_STEP;
          end
        end
        ST_PICK: begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          if (pick_hit_i) begin
            phase_o <= pick_idx_i;
            tuned_o <= pick_idx_i;
          end else begin
            err_o <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptune_engine.sv
module ptune_engine #(
  parameter int PHASE_W     = 3,
  parameter int RESET_PHASE = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               trial_ack_i,
  input  logic               trial_pass_i,
  output logic               trial_req_o,
  output logic [PHASE_W-1:0] sample_phase_o,
  output logic [PHASE_W-1:0] tuned_phase_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o
);
  localparam int N_PHASE = 1 << PHASE_W;

  logic [N_PHASE-1:0] pass_mask;
  logic               pick_hit;
  logic [PHASE_W-1:0] pick_idx;

  ptune_window_search #(.PHASE_W(PHASE_W)) u_search (
    .mask_i (pass_mask),
    .hit_o  (pick_hit),
    .idx_o  (pick_idx)
  );

  ptune_sweep_ctrl #(
    .PHASE_W     (PHASE_W),
    .RESET_PHASE (RESET_PHASE)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ack_i      (trial_ack_i),
    .pass_i     (trial_pass_i),
    .pick_hit_i (pick_hit),
    .pick_idx_i (pick_idx),
    .mask_o     (pass_mask),
    .phase_o    (sample_phase_o),
    .tuned_o    (tuned_phase_o),
    .req_o      (trial_req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (error_o)
  );
endmodule

// File: rtl/ptune_engine_chk.sv
module ptune_engine_chk #(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               trial_ack_i,
  input logic               trial_req_o,
  input logic [PHASE_W-1:0] sample_phase_o,
  input logic [PHASE_W-1:0] tuned_phase_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               error_o
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    (trial_req_o && !trial_ack_i) |=> trial_req_o);

  a_r3_phase_frozen: assert property (@(posedge clk) disable iff (rst)
    trial_req_o |=> $stable(sample_phase_o));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    $rose(trial_req_o) |-> (sample_phase_o == PHASE_W'($past(sample_phase_o) + 1'b1)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r10_req_in_sweep: assert property (@(posedge clk) disable iff (rst)
    trial_req_o |-> busy_o);

  a_r8_error_keeps_phase: assert property (@(posedge clk) disable iff (rst)
    (done_o && error_o) |-> $stable(sample_phase_o));

  a_r9_tuned_applied: assert property (@(posedge clk) disable iff (rst)
    (done_o && !error_o) |-> (tuned_phase_o == sample_phase_o));
endmodule

bind ptune_engine ptune_engine_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .trial_ack_i    (trial_ack_i),
  .trial_req_o    (trial_req_o),
  .sample_phase_o (sample_phase_o),
  .tuned_phase_o  (tuned_phase_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .error_o        (error_o)
);

// File: tb/ptune_engine_test.sv
`timescale 1ns/1ps
module ptune_engine_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       trial_ack_i = 1'b0;
  logic       trial_pass_i = 1'b0;
  logic       trial_req_o;
  logic [2:0] sample_phase_o;
  logic [2:0] tuned_phase_o;
  logic       busy_o, done_o, error_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_phase;
  logic [2:0] exp_tuned;

  always #2 clk = ~clk;

  ptune_engine uut (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .trial_ack_i    (trial_ack_i),
    .trial_pass_i   (trial_pass_i),
    .trial_req_o    (trial_req_o),
    .sample_phase_o (sample_phase_o),
    .tuned_phase_o  (tuned_phase_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .error_o        (error_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ror8(input logic [7:0] v, input int s);
    return (v >> s) | (v << (8 - s));
  endfunction

  // returns chosen phase or -1; tier is 1..3 (0 when nothing passed)
  function automatic int model_pick(input logic [7:0] m, output int tier);
    logic [7:0] pats [3];
    pats[0] = 8'hC7; pats[1] = 8'h83; pats[2] = 8'h01;
    tier = 0;
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 8; i++)
        if ((ror8(m, i) & pats[t]) == pats[t]) begin
          tier = t + 1;
          return i;
        end
    return -1;
  endfunction

  task automatic run_session(input logic [7:0] m, input bit poke_start);
    logic [2:0] origin;
    logic [2:0] held;
    int waited, e, tier;
    bit seen_done;
    string tag;
    origin = exp_phase;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    for (int k = 0; k < 8; k++) begin
      waited = 0;
      while (!trial_req_o && waited < 50) begin
        @(negedge clk);
        waited++;
      end
      check(trial_req_o == 1'b1, "R2 trial request", trial_req_o, 1);
      check(sample_phase_o == 3'(origin + k + 1), "R2 trial phase order",
            sample_phase_o, 3'(origin + k + 1));
      held = sample_phase_o;
      for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
        if (poke_start && k == 3 && w == 0) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(trial_req_o == 1'b1 && sample_phase_o == held, "R3 hold until ack",
              sample_phase_o, held);
      end
      if (poke_start && k == 3) begin
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
      trial_ack_i  = 1'b1;
      trial_pass_i = m[sample_phase_o];
      @(negedge clk);
      trial_ack_i  = 1'b0;
      trial_pass_i = 1'b0;
    end
    seen_done = 1'b0;
    for (int w = 0; w < 20 && !seen_done; w++) begin
      @(negedge clk);
      if (trial_req_o) check(1'b0, "R11 extra trial after eight", 9, 8);
      if (done_o) seen_done = 1'b1;
    end
    check(seen_done, "R10 done pulse", seen_done, 1);
    e = model_pick(m, tier);
    if (e < 0) begin
      check(error_o == 1'b1, "R8 error flag", error_o, 1);
      check(sample_phase_o == origin, "R8 phase kept", sample_phase_o, origin);
      check(tuned_phase_o == exp_tuned, "R8 tuned kept", tuned_phase_o, exp_tuned);
    end else begin
      tag = (tier == 1) ? "R5 wide window pick" :
            (tier == 2) ? "R6 narrow window pick" : "R7 single pass pick";
      check(error_o == 1'b0, "R9 no error", error_o, 0);
      check(sample_phase_o == 3'(e), tag, sample_phase_o, e);
      check(tuned_phase_o == 3'(e), "R9 tuned stored", tuned_phase_o, e);
      check(sample_phase_o == 3'(e), "R4 mask capture via pick", sample_phase_o, e);
      exp_phase = 3'(e);
      exp_tuned = 3'(e);
    end
    @(negedge clk);
    check(done_o == 1'b0, "R10 done one cycle", done_o, 0);
    check(busy_o == 1'b0, "R10 idle after done", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sample_phase_o == 3'd0, "R1 phase reset", sample_phase_o, 0);
    check(tuned_phase_o == 3'd0, "R1 tuned reset", tuned_phase_o, 0);
    check({trial_req_o, busy_o, done_o, error_o} == 4'b0, "R1 flags reset",
          {trial_req_o, busy_o, done_o, error_o}, 0);
    exp_phase = 3'd0;
    exp_tuned = 3'd0;

    // acknowledge with no pending request is ignored (R3)
    trial_ack_i = 1'b1; trial_pass_i = 1'b1;
    repeat (2) @(negedge clk);
    trial_ack_i = 1'b0; trial_pass_i = 1'b0;
    @(negedge clk);
    check(trial_req_o == 1'b0 && busy_o == 1'b0 && sample_phase_o == exp_phase,
          "R3 stray ack ignored", sample_phase_o, exp_phase);

    run_session(8'hFF, 1'b0);  // R5 -> 0
    run_session(8'h7C, 1'b0);  // R5 -> 4
    run_session(8'h0E, 1'b0);  // R6 -> 2
    run_session(8'hC3, 1'b0);  // R6 wrap -> 0
    run_session(8'h80, 1'b0);  // R7 -> 7
    run_session(8'h05, 1'b0);  // R7 -> 0
    run_session(8'h00, 1'b0);  // R8
    run_session(8'h38, 1'b1);  // R11 start poke mid-sweep
    for (int n = 0; n < 24; n++) begin
      m = 8'($urandom());
      if (n % 4 == 1) m = m & 8'($urandom());
      run_session(m, n % 5 == 2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule